// File: doc/BRIEF.md
# Gate-Grouped Weighted Round Robin Arbiter

This arbiter chooses the next transmit channel, and the queue inside that channel, for each frame slot in a time-scheduled egress path. Only channels whose transmission gate is open can win. Weighted round robin runs only among those open channels. Any change in the set of open gates starts arbitration over with fresh credits. The result is that each gate window shares its bandwidth in the ratio of the weights of the channels open in it, and never in the ratio across all channels.

Each channel collects several queues. A per-channel round robin picks among them, and it passes over any queue whose head frame does not fit in the remaining open window. The caller gives one `fit` bit per queue and raises `pick` once for each frame decision. The arbiter returns a registered one-hot channel grant and a one-hot queue grant.

Top module: `gate_group_wrr`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gnt_vld`, `gnt_ch` and `gnt_q` are all zero.
- R2: A channel qualifies when it is gate-open, eligible, and has at least one queue with both request and fit set. Only a qualifying channel can be granted.
- R3: A `pick` sampled on a rising edge while at least one channel qualifies produces, after that edge, a single cycle with `gnt_vld` high. In that cycle `gnt_ch` and `gnt_q` each have exactly one bit set. Without `pick`, `gnt_vld` is low in the next cycle.
- R4: Each channel holds a credit. Every grant lowers the winner's credit by one. The next winner is the first credited qualifying channel found by searching upward from the index after the previous winner, wrapping from 7 to 0. With weights 4 and 3 on open channels 3 and 2 and a fresh start, the grant order is 2,3,2,3,2,3,3.
- R5: When no qualifying channel has credit left, all credits reload from the weights and the search continues from after the last winner.
- R6: Any change of `gate_open` compared with the previous cycle reloads every credit from its weight. It also sets the channel search and every queue pointer back to index 0. This takes effect for a `pick` in that same cycle.
- R7: A weight of 0 acts as a weight of 1.
- R8: Within the granted channel, the queue is chosen round robin, searching upward from after that channel's last granted queue. Queues whose fit bit is low are skipped.
- R9: A channel whose gate is closed is never granted. If no channel qualifies, `pick` produces no grant.
- R10: Queue q of channel c is at bit c*4+q of `q_req`, `q_fit` and `gnt_q`. The weight of channel c is `weight[c*4 +: 4]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pick | input | 1 | Request one arbitration decision this cycle |
| gate_open | input | 8 | Per-channel gate state, 1 = open |
| ch_elig | input | 8 | Per-channel eligibility from the selection logic |
| q_req | input | 32 | Per-queue frame pending |
| q_fit | input | 32 | Per-queue head frame fits in the open window |
| weight | input | 32 | Per-channel 4-bit weights |
| gnt_vld | output | 1 | Grant valid |
| gnt_ch | output | 8 | One-hot channel grant |
| gnt_q | output | 32 | One-hot queue grant |

## Verification
Every grant is registered once, so the result of a `pick` sampled on one rising edge is visible for exactly the cycle that follows. The bench sets inputs on a falling edge and reads the grant on the next falling edge. Each step is therefore one decision with its result checked half a period after the edge that made it. Gate changes are applied in the same step as the `pick` they should affect, because the restart works on the gate value seen at that edge. Long grant orders are checked step by step, so a wrong pointer or a credit that is off by one shows up at the exact grant where it first matters.

// File: rtl/gate_group_wrr.sv
module gate_group_wrr #(
  parameter int NCH = 8,
  parameter int NQ  = 4,
  parameter int WW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick,
  input  logic [NCH-1:0]    gate_open,
  input  logic [NCH-1:0]    ch_elig,
  input  logic [NCH*NQ-1:0] q_req,
  input  logic [NCH*NQ-1:0] q_fit,
  input  logic [NCH*WW-1:0] weight,
  output logic              gnt_vld,
  output logic [NCH-1:0]    gnt_ch,
  output logic [NCH*NQ-1:0] gnt_q
);
  localparam int CW = $clog2(NCH);
  localparam int QW = $clog2(NQ);

  logic [WW-1:0]     cred [NCH];
  logic [QW-1:0]     qptr [NCH];
  logic [CW-1:0]     ptr;
  logic [NCH-1:0]    gate_q;

  logic              restart, refill, found, qfound;
  logic [NCH*NQ-1:0] qmask;
  logic [NCH-1:0]    ch_req, cand, has, pool;
  logic [WW-1:0]     w_eff [NCH];
  logic [WW-1:0]     cr_eff [NCH];
  logic [CW-1:0]     ptr_eff, win;
  logic [QW-1:0]     qp_eff, qwin;
  logic [NQ-1:0]     wq;

  assign restart = gate_open != gate_q;
  assign qmask   = q_req & q_fit;
  assign ptr_eff = restart ? '0 : ptr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_req[c] = |qmask[c*NQ +: NQ];
    assign w_eff[c]  = (weight[c*WW +: WW] == '0) ? WW'(1) : weight[c*WW +: WW];
    assign cr_eff[c] = restart ? w_eff[c] : cred[c];
    assign has[c]    = cr_eff[c] != '0;
  end

  assign cand   = ch_req & ch_elig & gate_open;
  assign refill = ((cand & has) == '0) && (cand != '0);
  assign pool   = refill ? cand : (cand & has);

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NCH; i++) begin
      int idx;
      idx = int'(ptr_eff) + i;
      if (idx >= NCH) idx = idx - NCH;
      if (!found && pool[idx]) begin
        found = 1'b1;
        win   = CW'(idx);
      end
    end
  end

  assign wq     = qmask[win*NQ +: NQ];
  assign qp_eff = restart ? '0 : qptr[win];

  always_comb begin
    qfound = 1'b0;
    qwin   = '0;
    for (int i = 0; i < NQ; i++) begin
      int idx;
      idx = int'(qp_eff) + i;
      if (idx >= NQ) idx = idx - NQ;
      if (!qfound && wq[idx]) begin
        qfound = 1'b1;
        qwin   = QW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q  <= '0;
      ptr     <= '0;
      gnt_vld <= 1'b0;
      gnt_ch  <= '0;
      gnt_q   <= '0;
      for (int c = 0; c < NCH; c++) begin
        cred[c] <= '0;
        qptr[c] <= '0;
      end
    end else begin
      gate_q  <= gate_open;
      gnt_vld <= 1'b0;
      gnt_ch  <= '0;
      gnt_q   <= '0;
      if (restart) begin
        ptr <= '0;
        for (int c = 0; c < NCH; c++) begin
          cred[c] <= w_eff[c];
          qptr[c] <= '0;
        end
      end
      if (pick && found) begin
        for (int c = 0; c < NCH; c++)
          cred[c] <= (refill ? w_eff[c] : cr_eff[c]) - ((CW'(c) == win) ? WW'(1) : WW'(0));
        ptr                        <= (win == CW'(NCH-1)) ? '0 : win + CW'(1);
        qptr[win]                  <= (qwin == QW'(NQ-1)) ? '0 : qwin + QW'(1);
        gnt_vld                    <= 1'b1;
        gnt_ch[win]                <= 1'b1;
        gnt_q[int'(win)*NQ + int'(qwin)] <= 1'b1;
      end
    end
  end

  // R2
  gnt_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((gnt_ch & $past(cand)) != '0));

  // R3
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_ch) && $onehot0(gnt_q));

  // R3
  pick_serves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick && cand != '0) |=> gnt_vld);

  // R3
  no_pick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick |=> !gnt_vld);

  // R8
  q_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ((gnt_q & $past(qmask)) != '0));

  // R10
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    q_in_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_ch[c] == (|gnt_q[c*NQ +: NQ]));
  end
endmodule

// File: tb/tb_gate_group_wrr.sv
module tb_gate_group_wrr;
  logic        clk = 0, rst_n = 0, pick = 0;
  logic [7:0]  gate_open = 0, ch_elig = 0;
  logic [31:0] q_req = 0, q_fit = 0, weight = 0;
  logic        gnt_vld;
  logic [7:0]  gnt_ch;
  logic [31:0] gnt_q;
  int checks = 0, failures = 0, cyc = 0;

  gate_group_wrr dut (.clk(clk), .rst_n(rst_n), .pick(pick), .gate_open(gate_open),
    .ch_elig(ch_elig), .q_req(q_req), .q_fit(q_fit), .weight(weight),
    .gnt_vld(gnt_vld), .gnt_ch(gnt_ch), .gnt_q(gnt_q));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // {gate, expected channel}: R4 order for weights 4:3, R5 refill, then 2:1 slot
  localparam logic [15:0] TBL [12] = '{
    {8'h0C,8'h04}, {8'h0C,8'h08}, {8'h0C,8'h04}, {8'h0C,8'h08},
    {8'h0C,8'h04}, {8'h0C,8'h08}, {8'h0C,8'h08}, {8'h0C,8'h04},
    {8'h03,8'h01}, {8'h03,8'h02}, {8'h03,8'h02}, {8'h03,8'h01}};

  function automatic logic [31:0] q0_of(input logic [7:0] ch);
    logic [31:0] r = '0;
    for (int c = 0; c < 8; c++) if (ch[c]) r[c*4] = 1'b1;
    return r;
  endfunction

  task automatic step(input logic [7:0] g, input logic [7:0] e, input logic [31:0] rq,
                      input logic [31:0] ft, input logic [31:0] w, input logic p,
                      input logic ev, input logic [7:0] ech, input logic [31:0] eq,
                      input string tag);
    gate_open = g; ch_elig = e; q_req = rq; q_fit = ft; weight = w; pick = p;
    @(negedge clk);
    checks++;
    if (gnt_vld !== ev || gnt_ch !== ech || gnt_q !== eq) begin
      failures++;
      $display("FAIL %s actual vld=%0b ch=%h q=%h expected vld=%0b ch=%h q=%h",
               tag, gnt_vld, gnt_ch, gnt_q, ev, ech, eq);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (gnt_vld !== 0 || gnt_ch !== 0 || gnt_q !== 0) begin
      failures++;
      $display("FAIL R1 actual vld=%0b ch=%h q=%h expected 0 0 0", gnt_vld, gnt_ch, gnt_q);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (gnt_vld !== 0 || gnt_ch !== 0) begin
      failures++;
      $display("FAIL R1 actual vld=%0b ch=%h expected 0 0", gnt_vld, gnt_ch);
    end

    for (int i = 0; i < 12; i++)
      step(TBL[i][15:8], 8'hFF, 32'h0000_1111, 32'hFFFF_FFFF, 32'h0000_4321, 1,
           1, TBL[i][7:0], q0_of(TBL[i][7:0]), i < 8 ? "R4 R5 slot A" : "R5 R6 slot B");

    // R9: closed gate excludes channel 1; no open requester gives no grant
    step(8'h01, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h01, 32'h1, "R9 closed");
    step(8'h01, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h01, 32'h1, "R9 closed");
    step(8'h00, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h4321, 1, 0, 8'h00, 32'h0, "R9 none");

    // R2: ineligible channel 2 skipped
    step(8'h0F, 8'h0B, 32'h1111, 32'hFFFF_FFFF, 32'h1111, 1, 1, 8'h01, 32'h0001, "R2 elig");
    step(8'h0F, 8'h0B, 32'h1111, 32'hFFFF_FFFF, 32'h1111, 1, 1, 8'h02, 32'h0010, "R2 elig");
    step(8'h0F, 8'h0B, 32'h1111, 32'hFFFF_FFFF, 32'h1111, 1, 1, 8'h08, 32'h1000, "R2 elig");
    step(8'h0F, 8'h0B, 32'h1111, 32'hFFFF_FFFF, 32'h1111, 1, 1, 8'h01, 32'h0001, "R2 R5 wrap");

    // R8 R10: channel 5 queues 1,2,3 requesting, queue 2 does not fit
    step(8'h20, 8'hFF, 32'h00E0_0000, 32'h00A0_0000, 32'h0020_0000, 1, 1, 8'h20, 32'h0020_0000, "R8 R10 q1");
    step(8'h20, 8'hFF, 32'h00E0_0000, 32'h00A0_0000, 32'h0020_0000, 1, 1, 8'h20, 32'h0080_0000, "R8 q3");
    step(8'h20, 8'hFF, 32'h00E0_0000, 32'h00A0_0000, 32'h0020_0000, 1, 1, 8'h20, 32'h0020_0000, "R8 wrap");

    // R7: weight 0 on channel 0 acts as 1
    step(8'h03, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h10, 1, 1, 8'h01, 32'h01, "R7");
    step(8'h03, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h10, 1, 1, 8'h02, 32'h10, "R7");
    step(8'h03, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h10, 1, 1, 8'h01, 32'h01, "R7");
    step(8'h03, 8'hFF, 32'h11, 32'hFFFF_FFFF, 32'h10, 1, 1, 8'h02, 32'h10, "R7");

    // R6: gate change mid-round restarts the search at 0
    step(8'h0C, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h04, 32'h0100, "R6 pre");
    step(8'h0C, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h08, 32'h1000, "R6 pre");
    step(8'h0C, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h04, 32'h0100, "R6 pre");
    step(8'h0E, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h02, 32'h0010, "R6 restart");
    step(8'h0E, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 1, 1, 8'h04, 32'h0100, "R6 R4 after");

    // R3: no pick, no grant
    step(8'h0E, 8'hFF, 32'h1111, 32'hFFFF_FFFF, 32'h4321, 0, 0, 8'h00, 32'h0, "R3 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule